// File: doc/BRIEF.md
# Dual-Rail Carry-Completion Ripple Adder

This block is a clocked model of a self-timed ripple-carry adder. A one-cycle start pulse captures two W-bit operands and a carry-in. Every carry position then holds two rails: one that says "carry is 1" and one that says "carry is 0". When both rails are low, the carry at that position is not yet known. On each clock edge, each bit stage works out a new rail pair from its own generate, propagate and kill terms and from the rail pair below it. A carry can therefore move at most one bit position per cycle.

When every one of the W+1 carry positions shows a known value, the block raises `done`. The sum and carry-out are valid from that cycle on. The latency therefore depends on the data. Bits that generate or kill settle at once, so the latency follows the longest chain of propagate bits that a carry actually has to cross. A system would pulse `start`, wait for `done`, and then read `sum` and `carryOut`. A new pulse on `start` begins the next addition at any time.

Top module: `selfTimedAdder`

## Requirements
- R1: After reset, and until the first start pulse, `done` is low.
- R2: While `done` is high, `sum` equals the low W bits of opA + opB + carryIn, as captured on the start edge. For every bit, generate is x AND y, propagate is x XOR y, and kill is NOR(x, y). The 1-rail of carry position i+1 is the generate term, or the propagate term AND the 1-rail of position i. The 0-rail is the kill term, or the propagate term AND the 0-rail of position i. No position ever has both rails high.
- R3: While `done` is high, `carryOut` equals bit W of opA + opB + carryIn.
- R4: Call the start clock edge edge 0. `done` is first seen after clock edge T, and T is computed as follows. For each carry position k from 1 to W, let L be the number of consecutive propagate bits directly below k (bits k-1, k-2, ...). Position k settles at edge k if L equals k, and at edge L+1 otherwise. T is the largest of these values. T therefore lies between 1 and W.
- R5: Once `done` is high, it stays high, and `sum` and `carryOut` hold their values, until the next start pulse.
- R6: After a clock edge at which `start` is high, `done` is low. This holds even when an earlier result was complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Capture operands and carry-in, and begin a new addition |
| opA | input | W | First operand |
| opB | input | W | Second operand |
| carryIn | input | 1 | Carry into bit 0 |
| sum | output | W | Sum bits; valid while done is high |
| carryOut | output | 1 | Carry out of bit W-1; valid while done is high |
| done | output | 1 | All carry positions have settled |

## Verification
The tests use several kinds of operand pair, and each one separates a different part of the timing:
- Pairs with no propagate bits must finish in a single cycle, whatever their generate and kill pattern.
- Pairs whose bits all propagate must take the full W cycles. They are tried with both carry-in values, which drives a 1 and then a 0 down the whole chain.
- A propagate run that starts above a generate bit shows the extra cycle that a run not anchored at bit 0 costs.
- A seeded sweep of mixed operands compares sum, carry-out and latency against a model of each.

Holding the result for several idle cycles, and then restarting on a completed result, checks that `done` is kept and then cleared.

// File: rtl/selfTimedAdderPkg.sv
package selfTimedAdderPkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;     // capture operands, clear carry pairs
    logic advance;  // let every stage latch its next carry pair
  } adderStrobeT;

  // Dual-rail carry: railOne=known 1, railZero=known 0, both low=unknown
  typedef struct packed {
    logic railOne;
    logic railZero;
  } carryPairT;

endpackage

// File: rtl/adderBitStage.sv
module adderBitStage
  import selfTimedAdderPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  adderStrobeT strobes,
  input  logic        xBit,
  input  logic        yBit,
  input  carryPairT   pairIn,
  output carryPairT   pairOut
);

  logic genTerm;
  logic propTerm;
  logic killTerm;
  carryPairT pairNext;

  always_comb begin
    genTerm  = xBit & yBit;
    propTerm = xBit ^ yBit;
    killTerm = ~(xBit | yBit);
    pairNext.railOne  = genTerm  | (propTerm & pairIn.railOne);
    pairNext.railZero = killTerm | (propTerm & pairIn.railZero);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pairOut <= '0;
    end else if (strobes.load) begin
      pairOut <= '0;
    end else if (strobes.advance) begin
      pairOut <= pairNext;
    end
  end

endmodule

// File: rtl/adderDatapath.sv
module adderDatapath
  import selfTimedAdderPkg::*;
#(
  parameter int W = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  adderStrobeT strobes,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic         carryIn,
  output logic [W-1:0] sum,
  output logic         carryOut,
  output logic [W:0]   carryOne,
  output logic [W:0]   carryZero,
  output logic         allComplete
);

  logic [W-1:0] aReg;
  logic [W-1:0] bReg;
  carryPairT    pairs [W+1];

  // Position 0 is known as soon as the operands are captured
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aReg     <= '0;
      bReg     <= '0;
      pairs[0] <= '0;
    end else if (strobes.load) begin
      aReg     <= opA;
      bReg     <= opB;
      pairs[0] <= '{railOne: carryIn, railZero: ~carryIn};
    end
  end

  for (genvar i = 0; i < W; i++) begin : gStage
    adderBitStage uStage (
      .clk     (clk),
      .rstN    (rstN),
      .strobes (strobes),
      .xBit    (aReg[i]),
      .yBit    (bReg[i]),
      .pairIn  (pairs[i]),
      .pairOut (pairs[i+1])
    );
  end

  logic [W:0] settled;

  for (genvar k = 0; k <= W; k++) begin : gRails
    assign carryOne[k]  = pairs[k].railOne;
    assign carryZero[k] = pairs[k].railZero;
    assign settled[k]   = pairs[k].railOne | pairs[k].railZero;
  end

  assign allComplete = &settled;
  assign sum         = aReg ^ bReg ^ carryOne[W-1:0];
  assign carryOut    = carryOne[W];

endmodule

// File: rtl/adderControl.sv
module adderControl
  import selfTimedAdderPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        allComplete,
  output adderStrobeT strobes,
  output logic        done
);

  typedef enum logic {
    ST_IDLE,
    ST_RUN
  } ctrlStateT;

  ctrlStateT state;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else if (start) begin
      state <= ST_RUN;
    end
  end

  always_comb begin
    strobes.load    = start;
    strobes.advance = (state == ST_RUN) && !start;
    done            = (state == ST_RUN) && allComplete;
  end

endmodule

// File: rtl/selfTimedAdder.sv
module selfTimedAdder
  import selfTimedAdderPkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic         carryIn,
  output logic [W-1:0] sum,
  output logic         carryOut,
  output logic         done
);

  adderStrobeT strobes;
  logic        allComplete;
  logic [W:0]  carryOne;
  logic [W:0]  carryZero;

  adderControl uControl (
    .clk         (clk),
    .rstN        (rstN),
    .start       (start),
    .allComplete (allComplete),
    .strobes     (strobes),
    .done        (done)
  );

  adderDatapath #(.W(W)) uDatapath (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .opA         (opA),
    .opB         (opB),
    .carryIn     (carryIn),
    .sum         (sum),
    .carryOut    (carryOut),
    .carryOne    (carryOne),
    .carryZero   (carryZero),
    .allComplete (allComplete)
  );

endmodule

// File: rtl/selfTimedAdderChecker.sv
module selfTimedAdderChecker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rstN,
  input logic         start,
  input logic [W-1:0] sum,
  input logic         carryOut,
  input logic         done,
  input logic [W:0]   carryOne,
  input logic [W:0]   carryZero
);

  localparam int CW = $clog2(W + 2) + 1;

  logic          armed;
  logic [CW-1:0] sinceStart;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed      <= 1'b0;
      sinceStart <= '0;
    end else if (start) begin
      armed      <= 1'b1;
      sinceStart <= '0;
    end else if (armed && sinceStart <= CW'(W)) begin
      sinceStart <= sinceStart + 1'b1;
    end
  end

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !armed |-> !done);

  a_r2_rails_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    (carryOne & carryZero) == '0);

  a_r4_latency_bound: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !start && sinceStart >= CW'(W)) |-> done);

  a_r5_done_holds: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> done);

  a_r5_result_stable: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> ($stable(sum) && $stable(carryOut)));

  a_r6_start_clears: assert property (@(posedge clk) disable iff (!rstN)
    start |=> !done);

endmodule

bind selfTimedAdder selfTimedAdderChecker #(.W(W)) uChecker (
  .clk       (clk),
  .rstN      (rstN),
  .start     (start),
  .sum       (sum),
  .carryOut  (carryOut),
  .done      (done),
  .carryOne  (carryOne),
  .carryZero (carryZero)
);

// File: tb/test_selfTimedAdder.sv
module test_selfTimedAdder;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic         carryIn = 1'b0;
  logic [W-1:0] sum;
  logic         carryOut;
  logic         done;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #4 clk = ~clk;  // 125 MHz

  selfTimedAdder #(.W(W)) i_selfTimedAdder (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .opA      (opA),
    .opB      (opB),
    .carryIn  (carryIn),
    .sum      (sum),
    .carryOut (carryOut),
    .done     (done)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      failures++;
      $display("FAIL watchdog: actual cycles=%0d expected below 100000", cycles);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h", req, actual, expected);
    end
  endtask

  function automatic int expLatency(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] p;
    int worst;
    p = a ^ b;
    worst = 1;
    for (int k = 1; k <= W; k++) begin
      int run;
      int t;
      run = 0;
      for (int j = k - 1; j >= 0; j--) begin
        if (!p[j]) break;
        run++;
      end
      t = (run == k) ? k : run + 1;
      if (t > worst) worst = t;
    end
    return worst;
  endfunction

  // One addition: start, count edges to done, compare results
  task automatic runAdd(input logic [W-1:0] a, input logic [W-1:0] b, input logic cin);
    logic [W:0] full;
    int lat;
    full = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
    @(negedge clk);
    opA = a; opB = b; carryIn = cin; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R6 done low after start", int'(done), 0);
    lat = 0;
    while (!done && lat < 4 * W) begin
      @(negedge clk);
      lat++;
    end
    check("R4 latency", lat, expLatency(a, b));
    check("R2 sum", int'(sum), int'(full[W-1:0]));
    check("R3 carryOut", int'(carryOut), int'(full[W]));
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    check("R1 done low in reset", int'(done), 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 done low before start", int'(done), 0);
  endtask

  task automatic testNoPropagate();
    runAdd(8'h00, 8'h00, 1'b0);
    runAdd(8'hA5, 8'hA5, 1'b1);
    runAdd(8'h80, 8'h80, 1'b0);
  endtask

  task automatic testFullChain();
    runAdd(8'hFF, 8'h00, 1'b1);
    runAdd(8'hF0, 8'h0F, 1'b0);
  endtask

  task automatic testLiftedRun();
    runAdd(8'h0F, 8'h01, 1'b0);
    runAdd(8'h3C, 8'h44, 1'b1);
  endtask

  task automatic testHold();
    logic [W-1:0] held;
    logic heldC;
    runAdd(8'h5A, 8'h27, 1'b1);
    held = sum; heldC = carryOut;
    repeat (6) @(negedge clk);
    check("R5 done held", int'(done), 1);
    check("R5 sum held", int'(sum), int'(held));
    check("R5 carryOut held", int'(carryOut), int'(heldC));
  endtask

  task automatic testRestart();
    runAdd(8'h01, 8'h01, 1'b0);
    runAdd(8'h7F, 8'h01, 1'b0);
  endtask

  task automatic testSweep();
    logic [31:0] seed;
    seed = 32'h1d2c3b4a;
    for (int n = 0; n < 40; n++) begin
      seed = seed ^ (seed << 13);
      seed = seed ^ (seed >> 17);
      seed = seed ^ (seed << 5);
      runAdd(seed[7:0], seed[15:8], seed[16]);
    end
  endtask

  initial begin
    testReset();
    testNoPropagate();
    testFullChain();
    testLiftedRun();
    testHold();
    testRestart();
    testSweep();
    repeat (2) @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule